// File: doc/BRIEF.md
# Blank-Driven Active-Pixel Qualifier

This block sits at the pixel input of a video encoder. It decides which incoming pixels on each line are active when the blanking indication arrives from an external pin rather than from an internal timing generator. A transition of the blank pin to its active level opens a run of active pixels. The length of that run always comes from a programmed count, and the level of the pin after the transition does not change it. Each active pixel is tagged with its index within the run.

Some graphics controllers run at a character-clock rate instead of the pixel rate. For these, a dot mode changes the meaning of the blank pin. Each transition to the active level then marks the first pixel of a character. The block counts pixels from the horizontal sync and snaps that count up to the next multiple of the programmed character width, so the pixel count stays exact. In this mode the active region is a window on the line count: a programmed offset (the horizontal blanking length) and a programmed length define it.

Both pins have programmable polarity. The sync is active low by default. The blank pin, by default, takes its active level when the pin is high.

Top module: `blank_pixel_qualifier`

## Requirements
- R1: `blank_in` is sampled on every rising clock edge. Its active level is pin high when `blank_inv` is 0 and pin low when `blank_inv` is 1. A blank edge is a change of the sampled value from inactive to active.
- R2: With `dot_mode` 0, a blank edge first sampled at clock edge m starts a run, provided the run is armed and no sync leading edge is sampled at edge m. `pix_valid` is then high after edge m+1 with `pix_idx` 0, and `pix_idx` rises by one on each later clock.
- R3: A run lasts exactly `h_active` clocks, whatever the level of `blank_in` afterwards. `pix_idx` reads 0 whenever `pix_valid` is low.
- R4: Only one run starts per line. After an accepted blank edge, further blank edges are ignored until the next sync leading edge. A run accepted with `h_active` of 0 produces no valid pixels.
- R5: The sync is asserted when `hsync_in` is low (`hsync_inv` 0) or high (`hsync_inv` 1). A leading edge first sampled at edge k drives `pix_valid` low after edge k+1, ends any run and re-arms the block.
- R6: With `dot_mode` 1, if a sync leading edge is first sampled at edge k, pixel j is the one sampled at edge k+1+j and appears on the outputs after edge k+2+j. When no boundary occurs, its count n equals j. `pix_valid` is high exactly when `h_blank` <= n < `h_blank`+`h_active`, and `pix_idx` is then n-`h_blank`.
- R7: With `dot_mode` 1, a blank edge first sampled at edge m marks a character boundary and pulses `char_strobe` for the one clock after edge m+1. `char_strobe` stays 0 while `dot_mode` is 0.
- R8: At a boundary whose count n is not a multiple of the character width w (a `char_width` of 0 acts as 1), n is raised to the next multiple of w, and later pixels count on from there. A count already on a multiple is left unchanged.
- R9: When a blank edge and a sync leading edge are sampled at the same clock edge, the sync wins. No run starts, no strobe is produced and no realignment happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_in | input | 1 | External blank pin |
| hsync_in | input | 1 | External horizontal sync pin |
| blank_inv | input | 1 | Blank polarity select |
| hsync_inv | input | 1 | Sync polarity select |
| dot_mode | input | 1 | 1: blank edges are character boundaries |
| char_width | input | CW_W | Pixels per character in dot mode |
| h_blank | input | PIX_W | Dot-mode count of the first active pixel |
| h_active | input | PIX_W | Number of active pixels per line |
| pix_valid | output | 1 | Current pixel is active |
| pix_idx | output | PIX_W | Index of the active pixel within the line |
| char_strobe | output | 1 | One-clock pulse per character boundary |

## Verification
The bench builds the block with PIX_W=8 and CW_W=4. An 8-bit count holds a full line of test stimulus, and character widths of 8 and 9 fit with room to spare. These sizes put runs of up to 30 pixels within reach, under both polarities of each pin. They also cover boundaries that land on and off a character multiple, and a zero width. A zero-length run and simultaneous sync and blank edges can be reached in a few dozen clocks per case.

// File: rtl/bpq_pkg.sv
package bpq_pkg;

  // A character width of zero is treated as one pixel per character.
  function automatic int unsigned bpq_eff_width(int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

  // Raise a count to the next character multiple, given its phase in the character.
  function automatic int unsigned bpq_realign(int unsigned cnt, int unsigned ph, int unsigned w);
    return (ph == 0) ? cnt : cnt + (w - ph);
  endfunction

  // Phase of the following pixel inside a character.
  function automatic int unsigned bpq_next_phase(int unsigned ph, int unsigned w);
    return (ph + 1 >= w) ? 0 : ph + 1;
  endfunction

  // True when a count falls inside the active window.
  function automatic logic bpq_in_window(int unsigned n, int unsigned lo, int unsigned len);
    return (n >= lo) && (n < lo + len);
  endfunction

endpackage

// File: rtl/bpq_edge.sv
module bpq_edge #(
  parameter bit LOW_ACTIVE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic rise
);
  logic act, s_q, s_q2;

  generate
    if (LOW_ACTIVE) begin : g_low
      assign act = ~(pin ^ inv);
    end else begin : g_high
      assign act = pin ^ inv;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= 1'b0;
      s_q2 <= 1'b0;
    end else begin
      s_q  <= act;
      s_q2 <= s_q;
    end
  end

  assign rise = s_q & ~s_q2;

  assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bpq_run_ctrl.sv
module bpq_run_ctrl #(
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             b_rise,
  input  logic             hs_rise,
  input  logic [PIX_W-1:0] h_active,
  output logic             run_valid,
  output logic [PIX_W-1:0] run_idx
);
  logic armed_q;
  logic take, run_last, len_nonzero;

  assign len_nonzero = (h_active != '0);
  assign take        = b_rise & armed_q & ~run_valid & ~hs_rise;
  assign run_last    = run_valid & (run_idx == h_active - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_valid <= 1'b0;
      run_idx   <= '0;
      armed_q   <= 1'b1;
    end else if (hs_rise) begin
      run_valid <= 1'b0;
      run_idx   <= '0;
      armed_q   <= 1'b1;
    end else if (take) begin
      run_valid <= len_nonzero;
      run_idx   <= '0;
      armed_q   <= 1'b0;
    end else if (run_valid) begin
      if (run_last) begin
        run_valid <= 1'b0;
        run_idx   <= '0;
      end else begin
        run_idx <= run_idx + 1'b1;
      end
    end
  end

  assert_run_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && !run_last && !hs_rise) |=> (run_valid && (run_idx == $past(run_idx) + 1'b1)));

  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_last |=> !run_valid);

  assert_one_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !run_valid && !hs_rise) |=> !run_valid);

  assert_sync_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (!run_valid && armed_q));
endmodule

// File: rtl/bpq_char_track.sv
module bpq_char_track
  import bpq_pkg::*;
#(
  parameter int PIX_W = 11,
  parameter int CW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             b_rise,
  input  logic             hs_rise,
  input  logic             dot_mode,
  input  logic [CW_W-1:0]  char_width,
  input  logic [PIX_W-1:0] h_blank,
  input  logic [PIX_W-1:0] h_active,
  output logic             dot_valid,
  output logic [PIX_W-1:0] dot_idx,
  output logic             char_strobe
);
  localparam int unsigned      POS_MAX = (1 << PIX_W) - 1;
  localparam logic [PIX_W-1:0] POS_TOP = '1;

  logic [PIX_W-1:0] pos_q, aligned, cur;
  logic [CW_W-1:0]  ph_q;
  logic             boundary, in_win;
  int unsigned      w_eff, aligned_i;

  assign boundary = b_rise & ~hs_rise & dot_mode;

  always_comb begin
    w_eff     = bpq_eff_width(32'(char_width));
    aligned_i = bpq_realign(32'(pos_q), 32'(ph_q), w_eff);
    aligned   = (aligned_i > POS_MAX) ? POS_TOP : PIX_W'(aligned_i);
    cur       = boundary ? aligned : pos_q;
    in_win    = bpq_in_window(32'(cur), 32'(h_blank), 32'(h_active));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      ph_q        <= '0;
      dot_valid   <= 1'b0;
      dot_idx     <= '0;
      char_strobe <= 1'b0;
    end else begin
      char_strobe <= boundary;
      if (hs_rise) begin
        pos_q     <= '0;
        ph_q      <= '0;
        dot_valid <= 1'b0;
        dot_idx   <= '0;
      end else begin
        pos_q     <= (cur == POS_TOP) ? POS_TOP : cur + 1'b1;
        ph_q      <= CW_W'(bpq_next_phase(boundary ? 32'd0 : 32'(ph_q), w_eff));
        dot_valid <= dot_mode & in_win;
        dot_idx   <= (dot_mode & in_win) ? cur - h_blank : '0;
      end
    end
  end

  assert_strobe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    char_strobe |-> $past(dot_mode && b_rise));

  assert_boundary_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_strobe && dot_valid && $stable(char_width) && $stable(h_blank)
     && (32'(dot_idx) + 32'(h_blank) < POS_MAX))
    |-> (((32'(dot_idx) + 32'(h_blank)) % w_eff) == 0));

  assert_sync_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> !char_strobe);
endmodule

// File: rtl/blank_pixel_qualifier.sv
module blank_pixel_qualifier #(
  parameter int PIX_W = 11,
  parameter int CW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_in,
  input  logic             hsync_in,
  input  logic             blank_inv,
  input  logic             hsync_inv,
  input  logic             dot_mode,
  input  logic [CW_W-1:0]  char_width,
  input  logic [PIX_W-1:0] h_blank,
  input  logic [PIX_W-1:0] h_active,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_idx,
  output logic             char_strobe
);
  logic             b_rise, hs_rise;
  logic             run_valid, dot_valid;
  logic [PIX_W-1:0] run_idx, dot_idx;

  bpq_edge #(.LOW_ACTIVE(1'b0)) u_blank_edge (
    .clk (clk), .rst_n (rst_n), .pin (blank_in), .inv (blank_inv), .rise (b_rise)
  );

  bpq_edge #(.LOW_ACTIVE(1'b1)) u_sync_edge (
    .clk (clk), .rst_n (rst_n), .pin (hsync_in), .inv (hsync_inv), .rise (hs_rise)
  );

  bpq_run_ctrl #(.PIX_W(PIX_W)) u_run (
    .clk (clk), .rst_n (rst_n), .b_rise (b_rise), .hs_rise (hs_rise),
    .h_active (h_active), .run_valid (run_valid), .run_idx (run_idx)
  );

  bpq_char_track #(.PIX_W(PIX_W), .CW_W(CW_W)) u_char (
    .clk (clk), .rst_n (rst_n), .b_rise (b_rise), .hs_rise (hs_rise),
    .dot_mode (dot_mode), .char_width (char_width), .h_blank (h_blank),
    .h_active (h_active), .dot_valid (dot_valid), .dot_idx (dot_idx),
    .char_strobe (char_strobe)
  );

  assign pix_valid = dot_mode ? dot_valid : run_valid;
  assign pix_idx   = dot_mode ? dot_idx   : run_idx;

  assert_idle_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_idx == '0));

  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dot_mode && $past(!dot_mode)) |-> !char_strobe);
endmodule

// File: tb/blank_pixel_qualifier_bench.sv
module blank_pixel_qualifier_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PIX_W = 8;
  localparam int CW_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             blank_in = 1'b0;
  logic             hsync_in = 1'b1;
  logic             blank_inv = 1'b0;
  logic             hsync_inv = 1'b0;
  logic             dot_mode = 1'b0;
  logic [CW_W-1:0]  char_width = '0;
  logic [PIX_W-1:0] h_blank = '0;
  logic [PIX_W-1:0] h_active = '0;
  logic             pix_valid;
  logic [PIX_W-1:0] pix_idx;
  logic             char_strobe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  blank_pixel_qualifier #(.PIX_W(PIX_W), .CW_W(CW_W)) u_blank_pixel_qualifier (
    .clk (clk), .rst_n (rst_n), .blank_in (blank_in), .hsync_in (hsync_in),
    .blank_inv (blank_inv), .hsync_inv (hsync_inv), .dot_mode (dot_mode),
    .char_width (char_width), .h_blank (h_blank), .h_active (h_active),
    .pix_valid (pix_valid), .pix_idx (pix_idx), .char_strobe (char_strobe)
  );

  // Columns: sync inv, blank inv, h_active, gap after sync, blank hold, expected run length
  localparam int TAB [8][6] = '{
    '{0, 0,  5, 3, 10,  5},
    '{0, 1,  5, 3, 10,  5},
    '{1, 0,  7, 2,  3,  7},
    '{0, 0, 12, 2,  3, 12},
    '{0, 0,  1, 0,  5,  1},
    '{0, 0,  0, 4,  5,  0},
    '{1, 1, 30, 6, 40, 30},
    '{0, 0,  3, 1,  2,  3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_pulse();
    @(negedge clk) hsync_in = hsync_inv;
    @(negedge clk) hsync_in = ~hsync_inv;
  endtask

  task automatic run_line(input int hinv, input int binv, input int ha,
                          input int pre, input int hold, input int exp);
    int cnt = 0;
    int first = -1;
    bit strobe_seen = 1'b0;
    bit idx_ok = 1'b1;
    @(negedge clk);
    hsync_inv = 1'(hinv); hsync_in = ~1'(hinv);
    blank_inv = 1'(binv); blank_in = 1'(binv);
    h_active  = PIX_W'(ha);
    dot_mode  = 1'b0;
    sync_pulse();
    repeat (pre) @(negedge clk);
    blank_in = ~1'(binv);
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (char_strobe) strobe_seen = 1'b1;
      if (pix_valid) begin
        if (first < 0) first = c;
        if (int'(pix_idx) != cnt) idx_ok = 1'b0;
        cnt++;
      end else if (pix_idx != '0) idx_ok = 1'b0;
      if (c == hold) blank_in = 1'(binv);
    end
    blank_in = 1'(binv);
    check(cnt == exp, "R3 run length", cnt, exp);
    check(idx_ok, "R2 index sequence", 0, 1);
    if (exp > 0) check(first == 2, "R2 start latency", first, 2);
    check(!strobe_seen, "R7 strobe in run mode", int'(strobe_seen), 0);
  endtask

  task automatic dot_run(input int w, input int hb, input int ha, input int bj);
    int ew = (w == 0) ? 1 : w;
    int n = 0;
    bit ev;
    int ei;
    @(negedge clk);
    dot_mode = 1'b1; char_width = CW_W'(w);
    h_blank = PIX_W'(hb); h_active = PIX_W'(ha);
    blank_inv = 1'b0; blank_in = 1'b0;
    hsync_inv = 1'b0; hsync_in = 1'b1;
    @(negedge clk);
    hsync_in = 1'b0;
    blank_in = (bj == -1);
    for (int i = 1; i <= 33; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        int j = i - 3;
        if (j == bj && (n % ew) != 0) n = n + ew - (n % ew);
        ev = (n >= hb) && (n < hb + ha);
        ei = ev ? n - hb : 0;
        check(pix_valid == ev, "R6 dot valid", int'(pix_valid), int'(ev));
        check(int'(pix_idx) == ei, "R8 dot index", int'(pix_idx), ei);
        check(char_strobe == (j == bj), "R7 boundary strobe", int'(char_strobe), int'(j == bj));
        n++;
      end
      hsync_in = 1'b1;
      blank_in = ((i - 1) == bj);
    end
    blank_in = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    check(pix_valid == 1'b0, "R3 reset valid", int'(pix_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_valid == 1'b0, "R3 valid after reset", int'(pix_valid), 0);
    check(pix_idx == '0, "R3 index after reset", int'(pix_idx), 0);
    check(char_strobe == 1'b0, "R7 strobe after reset", int'(char_strobe), 0);

    // R1 R2 R3 R5: table of run-mode lines
    for (int r = 0; r < 8; r++)
      run_line(TAB[r][0], TAB[r][1], TAB[r][2], TAB[r][3], TAB[r][4], TAB[r][5]);

    // R4: a second blank edge in the same line is ignored
    run_line(0, 0, 3, 2, 2, 3);
    @(negedge clk) blank_in = 1'b1;
    cnt = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c == 2) blank_in = 1'b0;
      if (pix_valid) cnt++;
    end
    check(cnt == 0, "R4 second edge ignored", cnt, 0);
    sync_pulse();
    blank_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pix_valid == 1'b1, "R4 rearmed by sync", int'(pix_valid), 1);
    blank_in = 1'b0;

    // R5: sync leading edge cuts a run short
    h_active = 8'd20;
    sync_pulse();
    blank_in = 1'b1;
    repeat (5) @(negedge clk);
    check(pix_valid && pix_idx == 8'd3, "R5 run underway", int'(pix_idx), 3);
    hsync_in = 1'b0;
    @(negedge clk);
    check(pix_valid == 1'b1, "R5 still valid one clock later", int'(pix_valid), 1);
    hsync_in = 1'b1;
    @(negedge clk);
    check(pix_valid == 1'b0, "R5 cleared by sync", int'(pix_valid), 0);
    cnt = 0;
    repeat (6) begin
      @(negedge clk);
      if (pix_valid) cnt++;
    end
    check(cnt == 0, "R5 stays cleared without new edge", cnt, 0);
    blank_in = 1'b0;

    // R9: sync and blank edges on the same clock in run mode
    @(negedge clk);
    hsync_in = 1'b0; blank_in = 1'b1;
    @(negedge clk) hsync_in = 1'b1;
    cnt = 0;
    repeat (10) begin
      @(negedge clk);
      if (pix_valid) cnt++;
    end
    check(cnt == 0, "R9 sync beats blank in run mode", cnt, 0);
    blank_in = 1'b0;

    // R6 R7 R8 R9: dot mode
    dot_run(8, 4, 20, 5);
    dot_run(8, 4, 20, 16);
    dot_run(9, 0, 12, 3);
    dot_run(0, 2, 5, 3);
    dot_run(8, 4, 20, -1);
    dot_mode = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule